// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and a calendar date. It holds five packed BCD bytes: seconds, minutes, hours (24-hour), day of month and month. It advances by one second on each cycle where a once-per-second enable is high. Each field carries into the next when it passes its last value. The day field rolls back to 01 and advances the month once it passes the last day of the current month.

The month length is not read from a table. It is derived from the BCD month with a few bit operations:
- Months above 07 are decremented in BCD.
- An odd result gives 31 days.
- For an even result, masking out bit 1 gives zero only for February, which gets 28 days. Every other even result gives 30 days.

Leap years are not modelled, so February always has 28 days.

A synchronous load port writes all five fields at once. The load wins over a tick that arrives in the same cycle.

Top module: `tod_calendar`

## Requirements
- R1: While rstN is low, the outputs read seconds 0x00, minutes 0x00, hours 0x00, day 0x01 and month 0x01.
- R2: In a cycle with neither secTick nor loadEn, no output field changes.
- R3: A tick advances seconds by one in packed BCD. The low nibble wraps from 9 to 0 and carries into the high nibble. Seconds roll from 0x59 to 0x00.
- R4: Minutes advance by one (BCD, 0x59 to 0x00) only on a tick where seconds roll over. Otherwise they hold.
- R5: Hours advance by one (BCD, 0x23 to 0x00) only on a tick where both seconds and minutes roll over.
- R6: Day length by BCD month:
  - 0x31 for months 01, 03, 05, 07, 08, 10 and 12;
  - 0x30 for months 04, 06, 09 and 11;
  - 0x28 for month 02, with no leap year.
  On a midnight rollover from the last day, day becomes 0x01 and the month advances. A loaded day at or beyond the length also rolls over at the next midnight.
- R7: The month rolls from 0x12 to 0x01 when the last day of December ends.
- R8: When loadEn is high at a clock edge, all five fields take the load values, whether or not secTick is high.
- R9: The effect of a tick or a load appears on the outputs at the clock edge that samples it, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| secTick | input | 1 | One-cycle enable, once per second |
| loadEn | input | 1 | Synchronous load of all fields |
| loadSec | input | 8 | BCD seconds to load |
| loadMin | input | 8 | BCD minutes to load |
| loadHour | input | 8 | BCD hours to load |
| loadDay | input | 8 | BCD day to load |
| loadMonth | input | 8 | BCD month to load |
| sec | output | 8 | BCD seconds |
| min | output | 8 | BCD minutes |
| hour | output | 8 | BCD hours |
| day | output | 8 | BCD day of month |
| month | output | 8 | BCD month |

## Verification
The bench runs a little over two hours of time tick by tick from reset. This catches a nibble that fails to wrap at 9, which would show 0x0A, and a minute that steps on the wrong tick.

Every hour value is then loaded just before its rollover, so a design with a wrong hour limit would wrap at 0x24 or too early.

Every month is loaded both on its last day and on the day before it, just before midnight. A wrong parity or February mask shows up as a day of 0x29 or 0x31, or as an early jump to day 01. The December-to-January rollover catches a month that would reach 0x13.

Finally, a load issued together with a tick must land unchanged, and idle cycles must change nothing.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int NUM_FIELDS = 5;
  localparam int DIGIT_W    = 4;
  localparam int FIELD_W    = 2 * DIGIT_W;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;

  typedef logic [FIELD_W-1:0] bcdByte_t;

  // control -> datapath strobes
  typedef struct packed {
    logic                  load;
    logic [NUM_FIELDS-1:0] adv;
    logic [NUM_FIELDS-1:0] wrap;
  } todStrobe_t;

  function automatic bcdByte_t bcdInc(input bcdByte_t v);
    if (v[DIGIT_W-1:0] == DIGIT_W'(9))
      return {v[FIELD_W-1:DIGIT_W] + DIGIT_W'(1), {DIGIT_W{1'b0}}};
    return {v[FIELD_W-1:DIGIT_W], v[DIGIT_W-1:0] + DIGIT_W'(1)};
  endfunction

  function automatic bcdByte_t bcdDec(input bcdByte_t v);
    if (v[DIGIT_W-1:0] == {DIGIT_W{1'b0}})
      return {v[FIELD_W-1:DIGIT_W] - DIGIT_W'(1), DIGIT_W'(9)};
    return {v[FIELD_W-1:DIGIT_W], v[DIGIT_W-1:0] - DIGIT_W'(1)};
  endfunction

  // Month length through bit manipulation: no table
  function automatic bcdByte_t monthLength(input bcdByte_t m);
    bcdByte_t adj;
    adj = (m > 8'h07) ? bcdDec(m) : m;
    if (adj[0])
      return 8'h31;
    if ((adj & ~8'h02) == '0)
      return 8'h28;
    return 8'h30;
  endfunction
endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
(
  input  logic                  secTick,
  input  logic                  loadEn,
  input  logic [NUM_FIELDS-1:0] atLast,
  output todStrobe_t            strobe
);
  logic [NUM_FIELDS-1:0] advChain;

  assign advChain[0] = secTick;

  // each field advances when every lower field is at its last value
  genvar gi;
  generate
    for (gi = 1; gi < NUM_FIELDS; gi++) begin : g_carry
      assign advChain[gi] = advChain[gi-1] & atLast[gi-1];
    end
  endgenerate

  always_comb begin
    strobe.load = loadEn;
    strobe.adv  = advChain;
    strobe.wrap = advChain & atLast;
  end
endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter bcdByte_t SEC_LAST   = 8'h59,
  parameter bcdByte_t MIN_LAST   = 8'h59,
  parameter bcdByte_t HOUR_LAST  = 8'h23,
  parameter bcdByte_t MONTH_LAST = 8'h12,
  parameter bcdByte_t FIRST_DAY  = 8'h01,
  parameter bcdByte_t FIRST_MON  = 8'h01
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  todStrobe_t                          strobe,
  input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  loadVals,
  output logic [NUM_FIELDS-1:0][FIELD_W-1:0]  fields,
  output logic [NUM_FIELDS-1:0]               atLast
);
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] firstVal;
  bcdByte_t                           curLen;

  assign firstVal[F_SEC]  = '0;
  assign firstVal[F_MIN]  = '0;
  assign firstVal[F_HOUR] = '0;
  assign firstVal[F_DAY]  = FIRST_DAY;
  assign firstVal[F_MON]  = FIRST_MON;

  assign curLen = monthLength(fields[F_MON]);

  assign atLast[F_SEC]  = (fields[F_SEC]  == SEC_LAST);
  assign atLast[F_MIN]  = (fields[F_MIN]  == MIN_LAST);
  assign atLast[F_HOUR] = (fields[F_HOUR] == HOUR_LAST);
  assign atLast[F_DAY]  = (fields[F_DAY]  >= curLen);
  assign atLast[F_MON]  = (fields[F_MON]  == MONTH_LAST);

  genvar gf;
  generate
    for (gf = 0; gf < NUM_FIELDS; gf++) begin : g_field
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          fields[gf] <= firstVal[gf];
        else if (strobe.load)
          fields[gf] <= loadVals[gf];
        else if (strobe.adv[gf])
          fields[gf] <= strobe.wrap[gf] ? firstVal[gf] : bcdInc(fields[gf]);
      end
    end
  endgenerate
endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
  import tod_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       secTick,
  input  logic       loadEn,
  input  logic [7:0] loadSec,
  input  logic [7:0] loadMin,
  input  logic [7:0] loadHour,
  input  logic [7:0] loadDay,
  input  logic [7:0] loadMonth,
  output logic [7:0] sec,
  output logic [7:0] min,
  output logic [7:0] hour,
  output logic [7:0] day,
  output logic [7:0] month
);
  todStrobe_t                         strobe;
  logic [NUM_FIELDS-1:0]              atLast;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] loadVals;
  logic [NUM_FIELDS-1:0][FIELD_W-1:0] fields;

  assign loadVals[F_SEC]  = loadSec;
  assign loadVals[F_MIN]  = loadMin;
  assign loadVals[F_HOUR] = loadHour;
  assign loadVals[F_DAY]  = loadDay;
  assign loadVals[F_MON]  = loadMonth;

  tod_ctrl u_ctrl (
    .secTick (secTick),
    .loadEn  (loadEn),
    .atLast  (atLast),
    .strobe  (strobe)
  );

  tod_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadVals (loadVals),
    .fields   (fields),
    .atLast   (atLast)
  );

  assign sec   = fields[F_SEC];
  assign min   = fields[F_MIN];
  assign hour  = fields[F_HOUR];
  assign day   = fields[F_DAY];
  assign month = fields[F_MON];
endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk (
  input logic       clk,
  input logic       rstN,
  input logic       secTick,
  input logic       loadEn,
  input logic [7:0] loadSec,
  input logic [7:0] loadMin,
  input logic [7:0] loadHour,
  input logic [7:0] loadDay,
  input logic [7:0] loadMonth,
  input logic [7:0] sec,
  input logic [7:0] min,
  input logic [7:0] hour,
  input logic [7:0] day,
  input logic [7:0] month
);
  logic midnight;
  assign midnight = secTick && !loadEn && sec == 8'h59 && min == 8'h59 && hour == 8'h23;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !loadEn) |=> ($stable(sec) && $stable(min) && $stable(hour)
                               && $stable(day) && $stable(month)));

  // R8
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> (sec == $past(loadSec) && min == $past(loadMin) && hour == $past(loadHour)
                && day == $past(loadDay) && month == $past(loadMonth)));

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !loadEn && sec == 8'h59) |=> (sec == 8'h00));

  // R4
  min_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && !loadEn && sec != 8'h59) |=> $stable(min));

  // R5
  hour_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    midnight |=> (hour == 8'h00));

  // R6
  feb_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (midnight && month == 8'h02 && day == 8'h28) |=> (day == 8'h01 && month == 8'h03));

  // R7
  year_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (midnight && month == 8'h12 && day == 8'h31) |=> (day == 8'h01 && month == 8'h01));
endmodule

bind tod_calendar tod_calendar_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .secTick   (secTick),
  .loadEn    (loadEn),
  .loadSec   (loadSec),
  .loadMin   (loadMin),
  .loadHour  (loadHour),
  .loadDay   (loadDay),
  .loadMonth (loadMonth),
  .sec       (sec),
  .min       (min),
  .hour      (hour),
  .day       (day),
  .month     (month)
);

// File: tb/tod_calendar_test.sv
module tod_calendar_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       secTick = 1'b0;
  logic       loadEn = 1'b0;
  logic [7:0] loadSec = '0, loadMin = '0, loadHour = '0, loadDay = '0, loadMonth = '0;
  logic [7:0] sec, min, hour, day, month;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  tod_calendar uut (
    .clk(clk), .rstN(rstN), .secTick(secTick), .loadEn(loadEn),
    .loadSec(loadSec), .loadMin(loadMin), .loadHour(loadHour),
    .loadDay(loadDay), .loadMonth(loadMonth),
    .sec(sec), .min(min), .hour(hour), .day(day), .month(month)
  );

  function automatic logic [7:0] toBcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int daysOf(input int m);
    if (m == 2) return 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h (mo dd hh mm ss)", tag, act, exp);
    end
  endtask

  function automatic logic [39:0] snap();
    return {month, day, hour, min, sec};
  endfunction

  task automatic doTick();
    @(negedge clk) secTick = 1'b1;
    @(negedge clk) secTick = 1'b0;
  endtask

  task automatic doLoad(input int mo, input int dd, input int hh, input int mm, input int ss,
                        input bit withTick);
    @(negedge clk);
    loadEn = 1'b1; secTick = withTick;
    loadMonth = toBcd(mo); loadDay = toBcd(dd); loadHour = toBcd(hh);
    loadMin = toBcd(mm); loadSec = toBcd(ss);
    @(negedge clk);
    loadEn = 1'b0; secTick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while reset held
    check("R1 reset", snap(), {8'h01, 8'h01, 8'h00, 8'h00, 8'h00});
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    // R2 idle cycles hold
    check("R2 idle", snap(), {8'h01, 8'h01, 8'h00, 8'h00, 8'h00});

    // R3 R4 R5 R9: run from reset, checking one cycle after each tick
    for (int t = 1; t <= 7300; t++) begin
      doTick();
      check("R3/R4/R5/R9 sweep", snap(),
            {8'h01, 8'h01, toBcd(t / 3600), toBcd((t / 60) % 60), toBcd(t % 60)});
    end

    // R2 hold after a run
    repeat (5) @(negedge clk);
    check("R2 idle after sweep", snap(), {8'h01, 8'h01, toBcd(2), toBcd(1), toBcd(40)});

    // R5 every hour rollover
    for (int h = 0; h < 24; h++) begin
      doLoad(5, 10, h, 59, 59, 1'b0);
      doTick();
      check("R5 hour step", snap(),
            {8'h05, (h == 23) ? 8'h11 : 8'h10, toBcd((h + 1) % 24), 8'h00, 8'h00});
    end

    // R6 R7 month lengths: day before last, and last day
    for (int m = 1; m <= 12; m++) begin
      doLoad(m, daysOf(m) - 1, 23, 59, 59, 1'b0);
      doTick();
      check("R6 not yet end", snap(), {toBcd(m), toBcd(daysOf(m)), 24'h000000});
      doLoad(m, daysOf(m), 23, 59, 59, 1'b0);
      doTick();
      check((m == 12) ? "R7 year wrap" : "R6 month end", snap(),
            {toBcd(m % 12 + 1), 8'h01, 24'h000000});
    end

    // R6 loaded day beyond month length rolls at midnight
    doLoad(2, 30, 23, 59, 59, 1'b0);
    doTick();
    check("R6 over-length day", snap(), {8'h03, 8'h01, 24'h000000});

    // R8 load with simultaneous tick takes load values exactly
    doLoad(7, 19, 23, 59, 59, 1'b1);
    check("R8 load beats tick", snap(), {8'h07, 8'h19, 8'h23, 8'h59, 8'h59});
    doLoad(11, 30, 8, 9, 9, 1'b0);
    check("R8 plain load", snap(), {8'h11, 8'h30, 8'h08, 8'h09, 8'h09});
    doTick();
    // R3 nibble carry 09 -> 10
    check("R3 nibble carry", snap(), {8'h11, 8'h30, 8'h08, 8'h09, 8'h10});

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule